// File: doc/BRIEF.md
# Multiplexed-DRAM-to-SRAM Bus Bridge

This bridge sits between a memory controller that expects multiplexed-address dynamic RAM and a flat, word-wide static RAM. The controller sends a row half-address, then a column half-address, on a single 9-bit bus. It marks each half with an active-low strobe. It writes single bytes through two active-low lane strobes, and a bank select chooses one of two halves of the memory. The bridge rebuilds the full word address from the two halves and drives the SRAM chip enable, output enable and per-lane write enables. It hands read data back as a 16-bit word in two parts: a byte that passes straight through while the column strobe is low, and a byte that is caught when the column strobe rises and held afterwards.

Every controller input is sampled by a fast local clock. The strobes go through two-flop synchronizers, and the address, data, bank and cycle-owner inputs follow the same two-stage delay so that they stay aligned with the strobes. Edges are taken from the synchronized strobes. A strobe change at the pins therefore reaches the SRAM controls on the third rising clock edge after it.

Refresh cycles are accepted without side effects. These are row strobes with no column strobe, stepping through all 512 row values.

Top module: `dram_sram_bridge`

## Requirements
- R1: The SRAM word address is {bank, column, row}: bits 8:0 are the 9-bit half captured at the row strobe's falling edge, bits 17:9 are the half captured at the column strobe's falling edge, and bit 18 is the bank select.
- R2: All controller strobes are active low with no inversion. A strobe edge at the pins reaches the SRAM control outputs on the third rising clock edge, so controls are settled four clocks after the pin change.
- R3: Lane strobe bit 0 writes SRAM data bits 7:0 and lane strobe bit 1 writes bits 15:8; the SRAM write enable of a lane (active low) follows only that lane's strobe.
- R4: Bank select 0 and 1 address distinct SRAM words for the same row and column.
- R5: During a read column phase (column strobe low, both lane strobes high) the direct read byte equals SRAM data bits 7:0 at the rebuilt address; otherwise it reads 0.
- R6: When the column strobe rises after a read, SRAM data bits 15:8 are held on the held-byte output until the next read ends.
- R7: The held-byte-wanted flag is 1 when the cycle-owner input was low (video owned) at the column strobe's fall, and 0 when it was high (processor owned). It updates together with the held byte.
- R8: In a write column phase only the lane whose strobe is low has its SRAM write enable asserted; the other lane's word byte is left unchanged.
- R9: A row strobe with no column strobe (refresh) asserts no chip, output or write enable and leaves the held byte unchanged.
- R10: Output enable is asserted only while the column phase is active and both lane strobes are high. The write data drive enable is asserted only during a write column phase, and both are released once the column strobe goes high.
- R11: A column strobe that falls while the row strobe is high asserts no SRAM enable and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mux_addr_i | input | 9 | Multiplexed row/column half-address |
| row_stb_n_i | input | 1 | Row strobe, active low |
| col_stb_n_i | input | 1 | Column strobe, active low |
| lane_wr_n_i | input | 2 | Per-lane byte write strobes, active low |
| bank_sel_i | input | 1 | Bank select |
| owner_cpu_i | input | 1 | Cycle owner: 1 processor, 0 video |
| wr_data_i | input | 16 | Write data, lane 0 in bits 7:0 |
| rd_direct_o | output | 8 | Pass-through read byte |
| rd_held_o | output | 8 | Held read byte |
| held_wanted_o | output | 1 | Held byte is used by this cycle's owner |
| sram_addr_o | output | 19 | SRAM word address |
| sram_ce_n_o | output | 1 | SRAM chip enable, active low |
| sram_oe_n_o | output | 1 | SRAM output enable, active low |
| sram_we_n_o | output | 2 | SRAM per-lane write enables, active low |
| sram_wdata_o | output | 16 | SRAM write data |
| sram_dq_oe_o | output | 1 | Write data drive enable |
| sram_rdata_i | input | 16 | SRAM read data |

## Verification
A wrong captured row or column value is visible on the address output as soon as the column phase opens, three clocks after the strobe. It also shows later as a byte stored in the wrong word, which a word read at the expected address exposes because the model memory tags each word with its full address. A column-phase flag that sticks or opens by mistake shows up at once on the chip-enable and write-enable pins, during a refresh or a column strobe without a row strobe. A stale or wrongly captured holding register appears on the held-byte output four clocks after the column strobe rises.

// File: rtl/bridge_pkg.sv
// Shared constants of the multiplexed-DRAM-to-SRAM bridge.
// Assumes a word-wide SRAM split into two byte lanes.
package bridge_pkg;
    localparam int HALF_W  = 9;
    localparam int WORD_W  = 16;
    localparam int LANES   = 2;
    localparam int LANE_W  = WORD_W / LANES;
    localparam int SRAM_AW = 2 * HALF_W + 1;
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/sync_pipe.sv
// Fixed-depth register pipe used both as a strobe synchronizer and as an
// alignment delay for the buses that must stay in step with the strobes.
// Assumes buses are stable long enough that the delayed copy is clean.
module sync_pipe #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n)      stage_q[s] <= RST_VAL;
                else if (s == 0) stage_q[s] <= d;
                else             stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/addr_rebuild.sv
// Captures the row and column halves on the synchronized strobe falls and
// tracks whether a column phase is open. Assumes the half-address pipe is
// delayed by the same stages as the strobes.
module addr_rebuild
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_s,
    input  logic              row_fall,
    input  logic              col_s,
    input  logic              col_fall,
    input  logic [HALF_W-1:0] half_s,
    input  logic              bank_s,
    input  logic              owner_s,
    output logic [HALF_W-1:0] row_q,
    output logic [HALF_W-1:0] col_q,
    output logic              bank_q,
    output logic              owner_q,
    output logic              col_active
);
    logic row_open_q;

    // Row half capture and row-open tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q      <= '0;
            row_open_q <= 1'b0;
        end else if (row_s) begin
            row_open_q <= 1'b0;
        end else if (row_fall) begin
            row_q      <= half_s;
            row_open_q <= 1'b1;
        end
    end

    // Column half capture; a column phase opens only inside an open row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q      <= '0;
            bank_q     <= 1'b0;
            owner_q    <= 1'b1;
            col_active <= 1'b0;
        end else if (row_s || col_s) begin
            col_active <= 1'b0;
        end else if (col_fall && row_open_q) begin
            col_q      <= half_s;
            bank_q     <= bank_s;
            owner_q    <= owner_s;
            col_active <= 1'b1;
        end
    end

    // R11
    col_needs_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_s |=> !col_active);
    // R9
    col_open_from_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_active) |-> $past(col_fall) && !$past(row_s));
endmodule

// File: rtl/read_steer.sv
// Generates SRAM enables from the column phase and lane strobes, passes the
// low byte straight through and holds the high byte at the column strobe rise.
// Assumes read data is valid while the column phase is still open.
module read_steer
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              col_active,
    input  logic              col_rise,
    input  logic              owner_q,
    input  logic [LANES-1:0]  lane_s,
    input  logic [WORD_W-1:0] rdata,
    output logic              ce_n,
    output logic              oe_n,
    output logic [LANES-1:0]  we_n,
    output logic              dq_oe,
    output logic [LANE_W-1:0] direct_o,
    output logic [LANE_W-1:0] held_o,
    output logic              wanted_o
);
    logic reading;
    logic [LANE_W-1:0] held_q;
    logic wanted_q;

    assign reading = col_active && (&lane_s);

    // Enable decode: each lane's write depends only on its own strobe.
    always_comb begin
        ce_n  = !col_active;
        oe_n  = !reading;
        dq_oe = col_active && !(&lane_s);
        for (int i = 0; i < LANES; i++)
            we_n[i] = !(col_active && !lane_s[i]);
    end

    assign direct_o = reading ? rdata[LANE_W-1:0] : '0;

    // Hold the upper byte when a read column phase closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q   <= '0;
            wanted_q <= 1'b0;
        end else if (col_rise && reading) begin
            held_q   <= rdata[WORD_W-1:LANE_W];
            wanted_q <= !owner_q;
        end
    end

    assign held_o   = held_q;
    assign wanted_o = wanted_q;

    // R10
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (&we_n));
    // R3
    we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&we_n) |-> !ce_n);
    // R9
    held_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(col_active) |-> $stable(held_q));
    // R10
    dq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !col_active |-> !dq_oe && oe_n);
endmodule

// File: rtl/dram_sram_bridge.sv
// Top of the bridge: synchronizes controller inputs, finds strobe edges,
// rebuilds the SRAM word address and steers read/write controls.
// Assumes clk is several times faster than the controller strobes.
module dram_sram_bridge
    import bridge_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HALF_W-1:0]  mux_addr_i,
    input  logic               row_stb_n_i,
    input  logic               col_stb_n_i,
    input  logic [LANES-1:0]   lane_wr_n_i,
    input  logic               bank_sel_i,
    input  logic               owner_cpu_i,
    input  logic [WORD_W-1:0]  wr_data_i,
    output logic [LANE_W-1:0]  rd_direct_o,
    output logic [LANE_W-1:0]  rd_held_o,
    output logic               held_wanted_o,
    output logic [SRAM_AW-1:0] sram_addr_o,
    output logic               sram_ce_n_o,
    output logic               sram_oe_n_o,
    output logic [LANES-1:0]   sram_we_n_o,
    output logic [WORD_W-1:0]  sram_wdata_o,
    output logic               sram_dq_oe_o,
    input  logic [WORD_W-1:0]  sram_rdata_i
);
    localparam int STB_W = LANES + 2;
    localparam int BUS_W = HALF_W + WORD_W + 2;

    logic [STB_W-1:0] stb_s, stb_prev;
    logic [BUS_W-1:0] bus_s;
    logic row_fall, col_fall, col_rise;
    logic [HALF_W-1:0] row_q, col_q;
    logic bank_q, owner_q, col_active;

    sync_pipe #(.W(STB_W), .STAGES(SYNC_STAGES), .RST_VAL({STB_W{1'b1}})) u_stb_sync (
        .clk(clk), .rst_n(rst_n),
        .d({lane_wr_n_i, col_stb_n_i, row_stb_n_i}), .q(stb_s));

    sync_pipe #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL({BUS_W{1'b0}})) u_bus_align (
        .clk(clk), .rst_n(rst_n),
        .d({owner_cpu_i, bank_sel_i, wr_data_i, mux_addr_i}), .q(bus_s));

    // Previous synchronized strobes for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_prev <= {STB_W{1'b1}};
        else        stb_prev <= stb_s;
    end

    assign row_fall = stb_prev[0] && !stb_s[0];
    assign col_fall = stb_prev[1] && !stb_s[1];
    assign col_rise = !stb_prev[1] && stb_s[1];

    addr_rebuild u_addr (
        .clk(clk), .rst_n(rst_n),
        .row_s(stb_s[0]), .row_fall(row_fall),
        .col_s(stb_s[1]), .col_fall(col_fall),
        .half_s(bus_s[HALF_W-1:0]),
        .bank_s(bus_s[BUS_W-2]), .owner_s(bus_s[BUS_W-1]),
        .row_q(row_q), .col_q(col_q), .bank_q(bank_q),
        .owner_q(owner_q), .col_active(col_active));

    read_steer u_steer (
        .clk(clk), .rst_n(rst_n),
        .col_active(col_active), .col_rise(col_rise), .owner_q(owner_q),
        .lane_s(stb_s[STB_W-1:2]), .rdata(sram_rdata_i),
        .ce_n(sram_ce_n_o), .oe_n(sram_oe_n_o), .we_n(sram_we_n_o),
        .dq_oe(sram_dq_oe_o), .direct_o(rd_direct_o),
        .held_o(rd_held_o), .wanted_o(held_wanted_o));

    assign sram_addr_o  = {bank_q, col_q, row_q};
    assign sram_wdata_o = bus_s[HALF_W +: WORD_W];

    // R1
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_active && $past(col_active)) |-> $stable(sram_addr_o));
endmodule

// File: tb/dram_sram_bridge_tb_top.sv
module dram_sram_bridge_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [8:0] mux_addr = '0;
    logic row_n = 1'b1, col_n = 1'b1, bank = 1'b0, owner = 1'b1;
    logic [1:0] lane_n = 2'b11;
    logic [15:0] wdata = '0;
    logic [7:0] rd_direct, rd_held;
    logic held_wanted, ce_n, oe_n, dq_oe;
    logic [18:0] saddr;
    logic [1:0] we_n;
    logic [15:0] swdata, srdata;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    dram_sram_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .mux_addr_i(mux_addr),
        .row_stb_n_i(row_n), .col_stb_n_i(col_n), .lane_wr_n_i(lane_n),
        .bank_sel_i(bank), .owner_cpu_i(owner), .wr_data_i(wdata),
        .rd_direct_o(rd_direct), .rd_held_o(rd_held), .held_wanted_o(held_wanted),
        .sram_addr_o(saddr), .sram_ce_n_o(ce_n), .sram_oe_n_o(oe_n),
        .sram_we_n_o(we_n), .sram_wdata_o(swdata), .sram_dq_oe_o(dq_oe),
        .sram_rdata_i(srdata));

    // Tagged model memory: a word is returned only when its full address matches.
    logic [18:0] tag_m [256];
    logic [15:0] dat_m [256];
    logic        vld_m [256];
    function automatic logic [7:0] fold(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'd0, a[18:16]};
    endfunction
    initial for (int i = 0; i < 256; i++) begin vld_m[i] = 1'b0; tag_m[i] = '0; dat_m[i] = '0; end
    always @(posedge clk) begin
        if (!ce_n && we_n != 2'b11) begin
            automatic logic [7:0] ix = fold(saddr);
            automatic logic [15:0] w = (vld_m[ix] && tag_m[ix] == saddr) ? dat_m[ix] : 16'h0000;
            if (!we_n[0]) w[7:0]  = swdata[7:0];
            if (!we_n[1]) w[15:8] = swdata[15:8];
            dat_m[ix] <= w; tag_m[ix] <= saddr; vld_m[ix] <= 1'b1;
        end
    end
    always_comb begin
        automatic logic [7:0] ix = fold(saddr);
        srdata = (vld_m[ix] && tag_m[ix] == saddr) ? dat_m[ix] : 16'hBAD0;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; settle();
        chk(ce_n && oe_n && we_n == 2'b11 && !dq_oe, "R2 reset idle",
            {ce_n, oe_n, we_n, dq_oe}, 5'b11110);
        chk(rd_held == 8'h00 && rd_direct == 8'h00, "R5 reset bytes", {rd_held, rd_direct}, 16'h0);
    endtask

    task automatic t_write(input logic b, input logic [8:0] r, input logic [8:0] c,
                           input int lane, input logic [7:0] v);
        @(negedge clk); mux_addr = r; row_n = 1'b0;
        // R2: row capture is not visible yet; enables stay idle
        settle();
        chk(ce_n, "R2 no enable before column", ce_n, 1'b1);
        mux_addr = c; bank = b; wdata = {v, v};
        lane_n = (lane == 0) ? 2'b10 : 2'b01; col_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(ce_n, "R2 latency not early", ce_n, 1'b1);
        @(negedge clk);
        chk(!ce_n, "R2 enable at third edge", ce_n, 1'b0);
        chk(saddr == {b, c, r}, "R1 R4 address rebuild", saddr, {b, c, r});
        chk(we_n == ((lane == 0) ? 2'b10 : 2'b01), "R3 R8 lane write", we_n,
            (lane == 0) ? 2'b10 : 2'b01);
        chk(oe_n && dq_oe, "R10 write phase drive", {oe_n, dq_oe}, 2'b11);
        col_n = 1'b1; lane_n = 2'b11; settle();
        chk(!dq_oe && ce_n && oe_n, "R10 release on column rise", {dq_oe, ce_n, oe_n}, 3'b011);
        row_n = 1'b1; settle();
    endtask

    task automatic t_read(input logic b, input logic [8:0] r, input logic [8:0] c,
                          input logic cpu, input logic [15:0] exp);
        @(negedge clk); mux_addr = r; row_n = 1'b0; settle();
        mux_addr = c; bank = b; owner = cpu; col_n = 1'b0; settle();
        chk(!oe_n && we_n == 2'b11, "R10 read output enable", {oe_n, we_n}, 3'b011);
        chk(rd_direct == exp[7:0], "R5 direct byte", rd_direct, exp[7:0]);
        col_n = 1'b1; owner = ~cpu; settle();
        chk(rd_held == exp[15:8], "R6 held byte", rd_held, exp[15:8]);
        chk(held_wanted == !cpu, "R7 held wanted flag", held_wanted, !cpu);
        chk(rd_direct == 8'h00, "R5 direct idle", rd_direct, 8'h00);
        row_n = 1'b1; settle();
        chk(rd_held == exp[15:8], "R6 held persists", rd_held, exp[15:8]);
    endtask

    task automatic t_refresh(input logic [7:0] held_exp);
        for (int r = 0; r < 512; r += 37) begin
            @(negedge clk); mux_addr = r[8:0]; row_n = 1'b0; lane_n = 2'b00;
            repeat (5) begin
                @(negedge clk);
                // R9: refresh must stay silent
                if (!ce_n || !oe_n || we_n != 2'b11) chk(1'b0, "R9 refresh enable", {ce_n, oe_n, we_n}, 4'b1111);
            end
            row_n = 1'b1; lane_n = 2'b11; settle();
        end
        chk(rd_held == held_exp, "R9 held unchanged by refresh", rd_held, held_exp);
    endtask

    task automatic t_col_only(input logic b, input logic [8:0] r, input logic [8:0] c);
        @(negedge clk); mux_addr = c; bank = b; wdata = 16'hEEEE; lane_n = 2'b00; col_n = 1'b0;
        repeat (3) @(negedge clk);
        mux_addr = r; row_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(ce_n && we_n == 2'b11, "R11 column without row ignored", {ce_n, we_n}, 3'b111);
        row_n = 1'b1; col_n = 1'b1; lane_n = 2'b11; settle();
    endtask

    initial begin
        #(200000 * 10);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_write(1'b0, 9'h155, 9'h0AA, 0, 8'h12);
        t_write(1'b0, 9'h155, 9'h0AA, 1, 8'h34);
        t_write(1'b1, 9'h155, 9'h0AA, 0, 8'h56);
        t_write(1'b1, 9'h155, 9'h0AA, 1, 8'h78);
        t_write(1'b0, 9'h003, 9'h1F0, 1, 8'h9A);
        t_write(1'b1, 9'h1C7, 9'h019, 0, 8'hBC);
        t_read(1'b0, 9'h155, 9'h0AA, 1'b1, 16'h3412);
        t_read(1'b1, 9'h155, 9'h0AA, 1'b0, 16'h7856);
        t_read(1'b0, 9'h003, 9'h1F0, 1'b0, 16'h9A00);
        t_read(1'b1, 9'h1C7, 9'h019, 1'b1, 16'h00BC);
        t_refresh(8'h00);
        t_col_only(1'b0, 9'h155, 9'h0AA);
        t_read(1'b0, 9'h155, 9'h0AA, 1'b0, 16'h3412);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule